// File: doc/BRIEF.md
# Pausable Framed Serial Register-Write Port

This block is the receiving end of a three-wire serial write path. It loads 24-bit words into one of two registers: a control register and a calibration register. The external serial clock, serial data, active-low frame strobe and address-select pin are asynchronous to the block. The system clock oversamples them through synchronizers. A word is shifted in most significant bit first. The first bit starts the word, and the address level seen at that bit decides which register the word is written to. Once the last bit has arrived, the chosen register is replaced in a single cycle and a one-cycle completion pulse is raised.

The frame strobe may be released in the middle of a word and asserted again later. Bits already received are kept, and the word continues from the position where it stopped. If the address pin changes level during a word, the partial word is dropped and a sticky error flag is raised. The converter's data-ready flag passes straight through the block and has no interaction with the write path.

Top module: `sreg_write_port`

## Requirements
- R1: A word is exactly 24 accepted bits, and the first accepted bit becomes bit 23 of the stored value.
- R2: A serial-clock rising edge is accepted only while the frame strobe is low. Rising edges while the strobe is high change no stored bit and do not advance the bit position.
- R3: If address-select is 0 at the first bit, the control register is written. If it is 1, the calibration register is written. The other register keeps its value.
- R4: The data-ready output always equals the data-ready input, whatever the state of the write path.
- R5: When the frame strobe goes high partway through a word, the bits received so far are kept. The next bit is taken at the first accepted rising edge after the strobe returns low.
- R6: The target register changes in the same clock as a one-cycle completion pulse, once per completed word, and at no other time.
- R7: If address-select differs from its first-bit level at any later accepted bit, the word is discarded, neither register changes, the error flag goes high and stays high until reset, and the next accepted bit starts a new word.
- R8: Reset clears both registers, the error flag, the completion pulse and the bit position, so a word interrupted by reset leaves no bits behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| sclk_i | input | 1 | External serial clock, idles low |
| sdata_i | input | 1 | Serial data, valid while the serial clock is high |
| frame_n_i | input | 1 | Active-low frame strobe, changes only while the serial clock is low |
| addr_sel_i | input | 1 | Register select: 0 control, 1 calibration |
| rdy_i | input | 1 | Data-ready flag from the converter |
| rdy_o | output | 1 | Data-ready flag, passed through |
| ctrl_o | output | 24 | Control register contents |
| cal_o | output | 24 | Calibration register contents |
| done_o | output | 1 | One-cycle pulse when a word has been written |
| err_o | output | 1 | Sticky flag: a word was discarded because the address changed |

## Verification
The bench pauses a word by raising the frame strobe and toggling the serial clock during the pause. A design that counted those toggles would store a shifted, corrupted value, or would finish the word early. The bench flips the address pin inside a word and then sends a clean word. A design that ignored the flip would write one register; one that failed to reset the bit position would merge the leftover bits into the next word. It also asserts reset in the middle of a word and toggles data-ready throughout, which catches stale bit counts and any gating of the flag.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic {
    TGT_CTRL = 1'b0,
    TGT_CAL  = 1'b1
  } tgt_e;

  typedef struct packed {
    logic addr;
    logic frame_n;
    logic data;
    logic sclk;
  } pins_t;

  localparam pins_t PINS_IDLE = '{addr: 1'b0, frame_n: 1'b1, data: 1'b0, sclk: 1'b0};

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sreg_frame_rx.sv
module sreg_frame_rx
  import sreg_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pins_t             pins,
  output logic              wr_en,
  output tgt_e              wr_tgt,
  output logic [WORD_W-1:0] wr_data,
  output logic              err
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  tgt_e              tgt_q, tgt_d;
  logic              err_q, err_d;
  logic              rise, take;

  assign rise = pins.sclk & ~sclk_prev_q;
  assign take = rise & ~pins.frame_n;

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tgt_d   = tgt_q;
    err_d   = err_q;
    wr_en   = 1'b0;
    wr_data = {sh_q[WORD_W-2:0], pins.data};
    if (take) begin
      if (cnt_q == '0) begin
        tgt_d = tgt_e'(pins.addr);
        sh_d  = {sh_q[WORD_W-2:0], pins.data};
        cnt_d = CNT_W'(1);
      end else if (tgt_e'(pins.addr) != tgt_q) begin
        err_d = 1'b1;
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        wr_en = 1'b1;
        cnt_d = '0;
      end else begin
        sh_d  = {sh_q[WORD_W-2:0], pins.data};
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
      tgt_q       <= TGT_CTRL;
      err_q       <= 1'b0;
    end else begin
      sclk_prev_q <= pins.sclk;
      cnt_q       <= cnt_d;
      sh_q        <= sh_d;
      tgt_q       <= tgt_d;
      err_q       <= err_d;
    end
  end

  assign wr_tgt = tgt_q;
  assign err    = err_q;

  // R2
  idle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && pins.frame_n) |=> $stable(cnt_q));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  tgt_e              wr_tgt,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ctrl,
  output logic [WORD_W-1:0] cal,
  output logic              done
);

  logic [WORD_W-1:0] ctrl_q, cal_q;
  logic              done_q;
  logic              ctrl_en, cal_en;

  assign ctrl_en = wr_en && (wr_tgt == TGT_CTRL);
  assign cal_en  = wr_en && (wr_tgt == TGT_CAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cal_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= wr_en;
      if (ctrl_en) ctrl_q <= wr_data;
      if (cal_en)  cal_q  <= wr_data;
    end
  end

  assign ctrl = ctrl_q;
  assign cal  = cal_q;
  assign done = done_q;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(ctrl_q) && $stable(cal_q)));

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($stable(ctrl_q) || $stable(cal_q)));

endmodule

// File: rtl/sreg_write_port.sv
module sreg_write_port
  import sreg_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              frame_n_i,
  input  logic              addr_sel_i,
  input  logic              rdy_i,
  output logic              rdy_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] cal_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int PIN_W = $bits(pins_t);

  pins_t             raw, synced;
  logic              wr_en;
  tgt_e              wr_tgt;
  logic [WORD_W-1:0] wr_data;

  assign raw = '{addr: addr_sel_i, frame_n: frame_n_i, data: sdata_i, sclk: sclk_i};

  sreg_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (synced)
  );

  sreg_frame_rx #(.WORD_W(WORD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins    (synced),
    .wr_en   (wr_en),
    .wr_tgt  (wr_tgt),
    .wr_data (wr_data),
    .err     (err_o)
  );

  sreg_bank #(.WORD_W(WORD_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_tgt  (wr_tgt),
    .wr_data (wr_data),
    .ctrl    (ctrl_o),
    .cal     (cal_o),
    .done    (done_o)
  );

  assign rdy_o = rdy_i;

endmodule

// File: tb/sreg_write_port_tb.sv
module sreg_write_port_tb_top;

  typedef struct packed {
    logic sclk;
    logic data;
    logic frame_n;
    logic addr;
  } smp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_i = 1'b0;
  logic        sdata_i = 1'b0;
  logic        frame_n_i = 1'b1;
  logic        addr_sel_i = 1'b0;
  logic        rdy_i = 1'b0;
  logic        rdy_o, done_o, err_o;
  logic [23:0] ctrl_o, cal_o;

  int total = 0;
  int failed = 0;
  int done_seen = 0;
  bit fin = 0;

  // behavioural reference state
  smp_t        hist[$];
  logic        bits[$];
  logic        m_tgt;
  logic        m_err;
  logic        m_done;
  logic [23:0] m_ctrl, m_cal;

  always #5 clk = ~clk;

  sreg_write_port dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_i     (sclk_i),
    .sdata_i    (sdata_i),
    .frame_n_i  (frame_n_i),
    .addr_sel_i (addr_sel_i),
    .rdy_i      (rdy_i),
    .rdy_o      (rdy_o),
    .ctrl_o     (ctrl_o),
    .cal_o      (cal_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  function automatic smp_t idle_smp();
    smp_t s;
    s.sclk = 1'b0; s.data = 1'b0; s.frame_n = 1'b1; s.addr = 1'b0;
    return s;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model, one step per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {idle_smp(), idle_smp(), idle_smp()};
      bits.delete();
      m_tgt = 1'b0; m_err = 1'b0; m_done = 1'b0;
      m_ctrl = '0; m_cal = '0;
    end else begin
      smp_t cur, prv, now;
      cur = hist[1];
      prv = hist[2];
      m_done = 1'b0;
      if (cur.sclk && !prv.sclk && !cur.frame_n) begin
        if (bits.size() == 0) begin
          m_tgt = cur.addr;
          bits.push_back(cur.data);
        end else if (cur.addr != m_tgt) begin
          m_err = 1'b1;
          bits.delete();
        end else begin
          bits.push_back(cur.data);
          if (bits.size() == 24) begin
            logic [23:0] v;
            v = '0;
            for (int k = 0; k < 24; k++) v[23-k] = bits[k];
            if (m_tgt) m_cal = v; else m_ctrl = v;
            m_done = 1'b1;
            bits.delete();
          end
        end
      end
      now.sclk = sclk_i; now.data = sdata_i; now.frame_n = frame_n_i; now.addr = addr_sel_i;
      hist.push_front(now);
      void'(hist.pop_back());
    end
  end

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (!fin) begin
      chk("R1/R3", "ctrl_o vs model", ctrl_o, m_ctrl);
      chk("R1/R3", "cal_o vs model", cal_o, m_cal);
      chk("R6", "done_o vs model", {23'd0, done_o}, {23'd0, m_done});
      chk("R7", "err_o vs model", {23'd0, err_o}, {23'd0, m_err});
      chk("R4", "rdy_o follows rdy_i", {23'd0, rdy_o}, {23'd0, rdy_i});
      if (done_o === 1'b1) done_seen++;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    @(negedge clk) sdata_i = d;
    wait_n(3);
    sclk_i = 1'b1;
    rdy_i  = ~rdy_i;
    wait_n(4);
    sclk_i = 1'b0;
    wait_n(1);
  endtask

  task automatic send_word(input logic [23:0] w, input logic a,
                           input int pause_at, input int flip_at);
    @(negedge clk);
    addr_sel_i = a;
    frame_n_i  = 1'b0;
    wait_n(2);
    for (int i = 0; i < 24; i++) begin
      if (i == pause_at) begin
        frame_n_i = 1'b1;
        wait_n(2);
        pulse(1'b1);
        pulse(1'b0);
        pulse(1'b1);
        frame_n_i = 1'b0;
        wait_n(2);
      end
      if (i == flip_at) begin
        addr_sel_i = ~a;
        wait_n(2);
      end
      pulse(w[23-i]);
      if (i == flip_at) break;
    end
    frame_n_i = 1'b1;
    wait_n(8);
  endtask

  initial begin
    int d0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(3);
    // R8: reset state
    chk("R8", "ctrl after reset", ctrl_o, 24'h0);
    chk("R8", "cal after reset", cal_o, 24'h0);
    chk("R8", "err after reset", {23'd0, err_o}, 24'h0);

    // R2: stray clocks with the strobe high are ignored
    pulse(1'b1); pulse(1'b1);
    chk("R2", "ctrl after idle clocks", ctrl_o, 24'h0);

    // R1, R3: control word, then calibration word
    d0 = done_seen;
    send_word(24'hA5C3F1, 1'b0, -1, -1);
    chk("R1", "control word", ctrl_o, 24'hA5C3F1);
    chk("R3", "cal untouched by control write", cal_o, 24'h0);
    chk("R6", "one done per word", done_seen - d0, 1);

    send_word(24'h3C0F81, 1'b1, -1, -1);
    chk("R3", "calibration word", cal_o, 24'h3C0F81);
    chk("R3", "ctrl untouched by cal write", ctrl_o, 24'hA5C3F1);

    // R5, R2: pause mid-word with clocks during the pause
    d0 = done_seen;
    send_word(24'h81F00D, 1'b0, 9, -1);
    chk("R5", "paused word", ctrl_o, 24'h81F00D);
    chk("R6", "one done for paused word", done_seen - d0, 1);
    send_word(24'h000001, 1'b1, 23, -1);
    chk("R5", "pause before last bit", cal_o, 24'h000001);

    // R7: address flip discards the word
    d0 = done_seen;
    send_word(24'hFFFFFF, 1'b0, -1, 5);
    chk("R7", "ctrl kept on discard", ctrl_o, 24'h81F00D);
    chk("R7", "cal kept on discard", cal_o, 24'h000001);
    chk("R7", "err set", {23'd0, err_o}, 24'h1);
    chk("R7", "no done on discard", done_seen - d0, 0);
    send_word(24'h5A5A5A, 1'b1, -1, -1);
    chk("R7", "next word starts clean", cal_o, 24'h5A5A5A);
    chk("R7", "err stays high", {23'd0, err_o}, 24'h1);

    // R8: reset in the middle of a word
    @(negedge clk) addr_sel_i = 1'b0; frame_n_i = 1'b0;
    for (int i = 0; i < 10; i++) pulse(1'b1);
    rst_n = 1'b0;
    wait_n(3);
    chk("R8", "ctrl cleared", ctrl_o, 24'h0);
    chk("R8", "err cleared", {23'd0, err_o}, 24'h0);
    frame_n_i = 1'b1;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(3);
    send_word(24'h123456, 1'b0, -1, -1);
    chk("R8", "no leftover bits after reset", ctrl_o, 24'h123456);
    chk("R4", "rdy pass-through at end", {23'd0, rdy_o}, {23'd0, rdy_i});

    fin = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule